// File: doc/BRIEF.md
# Two-Wire Multichannel Serial Readout Slave

This block sits between a host that owns a single clock/request line and an external converter that produces a set of 8-bit channel results. When the host pulls its line low while the block is idle, the block starts a conversion cycle. After a short busy delay it drives its single output line low and sends a one-cycle start pulse to the converter. When the converter answers with a done pulse, the block captures the whole result bus into a shift register and raises the output line to say that data is ready.

The host then clocks the frame out. Every rising edge of its line puts the next bit on the output line, and the host reads that bit while its line is low. A watchdog counts how long the host line stays high during shifting. If the line is high for longer than the timeout, the block drops the read and goes back to idle. The busy delay and the timeout come from a clock-frequency parameter and two durations in nanoseconds.

Data moves out with no back-pressure: the host's edges pace the stream, and a low phase may last as long as the host likes. The block accepts the converter's result in the same cycle that done is asserted, while it is in the converting state, so there is no ready signal on that side. The host line is asynchronous and passes through a synchroniser before its edges are detected.

Top module: `serial_readout_slave`

## Requirements
- R1: After reset, and while idle with the host line high, `sdo_o` is 1 and `conv_start_o` is 0.
- R2: While idle, a low host line starts a cycle. `sdo_o` goes to 0 between BUSY_CYC and BUSY_CYC+6 clock cycles after the host line falls, where BUSY_CYC is BUSY_NS converted to clock cycles and rounded up. `conv_start_o` pulses in the same cycle that `sdo_o` drops.
- R3: A `conv_done_i` pulse during the converting state captures `conv_data_i` and sets `sdo_o` back to 1 within a few cycles.
- R4: Each rising edge of the host line puts the next frame bit on `sdo_o`. Bit i of `conv_data_i` is sent as the i-th bit, so channel k sits in bits [8k+7:8k] and goes out least significant bit first, channel 0 first.
- R5: A `conv_done_i` pulse outside the converting state has no effect. The frame that is shifted out is the one captured earlier.
- R6: If the host line stays high for TIMEOUT_CYC cycles while shifting, the block returns to idle with `sdo_o` at 1. The next low level on the host line starts a new cycle.
- R7: The watchdog does not run before the first rising edge after conversion, and it never counts during low phases. A low phase longer than the timeout leaves the read intact.
- R8: After the falling edge that follows the last frame bit, a host line held low starts a fresh conversion cycle with a new `conv_start_o` pulse.
- R9: `conv_start_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_line_i | input | 1 | Host clock/request line, asynchronous, idles high |
| sdo_o | output | 1 | Busy flag, then serial data |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_done_i | input | 1 | Conversion-complete pulse |
| conv_data_i | input | NUM_CH*CH_BITS | Parallel results, channel k in bits [8k+7:8k] |

## Verification
The bench uses the default 11 channels of 8 bits. CLK_HZ is set to 20 MHz and the timeout to 20 us, which gives a 10-cycle busy delay and a 400-cycle watchdog. These values keep several full 88-bit frames, a mid-frame timeout and a low phase longer than the timeout inside a short run. The bench still exercises the real frame length, so the channel counter wraps at every byte boundary and the restart after the last bit occurs.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSYDLY,
    ST_CONVERT,
    ST_READY,
    ST_SHIFT
  } srs_state_e;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/srs_line_sync.sv
module srs_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RESET_VAL;
    else        prev <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/srs_delay_counter.sv
module srs_delay_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hit_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt;

  assign hit_o = run_i && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i || hit_o)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // Counter never passes its terminal count.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

  // A dropped run request always clears the count.
  assert_clear_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt == '0);

endmodule

// File: rtl/srs_frame_shifter.sv
module srs_frame_shifter #(
  parameter int unsigned NUM_CH  = 11,
  parameter int unsigned CH_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [NUM_CH*CH_BITS-1:0]   data_i,
  input  logic                        shift_i,
  output logic                        bit_o,
  output logic                        frame_done_o
);

  localparam int unsigned FRAME = NUM_CH * CH_BITS;
  localparam int unsigned BW    = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;
  localparam int unsigned CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [FRAME-1:0] shreg;
  logic [BW-1:0]    bit_idx;
  logic [CW-1:0]    ch_idx;
  logic             done_q;

  assign bit_o        = shreg[0];
  assign frame_done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      ch_idx  <= '0;
      done_q  <= 1'b0;
    end else if (load_i) begin
      shreg   <= data_i;
      bit_idx <= '0;
      ch_idx  <= '0;
      done_q  <= 1'b0;
    end else if (shift_i) begin
      shreg <= {1'b0, shreg[FRAME-1:1]};
      if (bit_idx == BW'(CH_BITS - 1)) begin
        bit_idx <= '0;
        if (ch_idx == CW'(NUM_CH - 1)) done_q <= 1'b1;
        else                           ch_idx <= ch_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // Channel index stays inside the frame.
  assert_ch_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_idx < CW'(NUM_CH));

  // Captured frame holds unless loaded or shifted (late done pulses ignored).
  assert_hold_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(shreg));

  // No shift requested once the whole frame has gone out.
  assert_no_overshift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !done_q);

endmodule

// File: rtl/serial_readout_slave.sv
module serial_readout_slave
  import srs_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BUSY_NS     = 500,
  parameter int unsigned TIMEOUT_NS  = 2_000_000,
  parameter int unsigned NUM_CH      = 11,
  parameter int unsigned CH_BITS     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_line_i,
  output logic                        sdo_o,
  output logic                        conv_start_o,
  input  logic                        conv_done_i,
  input  logic [NUM_CH*CH_BITS-1:0]   conv_data_i
);

  localparam int unsigned FRAME_BITS  = NUM_CH * CH_BITS;
  localparam int unsigned BUSY_CYC    = ns_to_cycles(CLK_HZ, BUSY_NS);
  localparam int unsigned TIMEOUT_CYC = ns_to_cycles(CLK_HZ, TIMEOUT_NS);

  srs_state_e state;
  logic line, line_rise, line_fall;
  logic busy_hit, tmo_run, tmo_hit;
  logic load, shift, frame_bit, frame_done;

  srs_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (host_line_i),
    .level_o (line),
    .rise_o  (line_rise),
    .fall_o  (line_fall)
  );

  srs_delay_counter #(.LIMIT(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state == ST_BUSYDLY),
    .hit_o (busy_hit)
  );

  // Watchdog runs only while shifting with the host line high; any edge clears it.
  assign tmo_run = (state == ST_SHIFT) && line && !line_rise;

  srs_delay_counter #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (tmo_run),
    .hit_o (tmo_hit)
  );

  assign load  = conv_done_i && (state == ST_CONVERT);
  assign shift = line_rise && ((state == ST_READY) || (state == ST_SHIFT));

  srs_frame_shifter #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .data_i       (conv_data_i),
    .shift_i      (shift),
    .bit_o        (frame_bit),
    .frame_done_o (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      sdo_o        <= 1'b1;
      conv_start_o <= 1'b0;
    end else begin
      conv_start_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sdo_o <= 1'b1;
          if (!line) state <= ST_BUSYDLY;
        end
        ST_BUSYDLY: begin
          if (busy_hit) begin
            state        <= ST_CONVERT;
            sdo_o        <= 1'b0;
            conv_start_o <= 1'b1;
          end
        end
        ST_CONVERT: begin
          if (conv_done_i) begin
            state <= ST_READY;
            sdo_o <= 1'b1;
          end
        end
        ST_READY: begin
          if (line_rise) begin
            state <= ST_SHIFT;
            sdo_o <= frame_bit;
          end
        end
        ST_SHIFT: begin
          if (tmo_hit) begin
            state <= ST_IDLE;
            sdo_o <= 1'b1;
          end else if (line_rise) begin
            sdo_o <= frame_bit;
          end else if (line_fall && frame_done) begin
            state <= ST_IDLE;
            sdo_o <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          sdo_o <= 1'b1;
        end
      endcase
    end
  end

  // Output line is high whenever no conversion or shift is under way.
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_BUSYDLY || state == ST_READY) |-> sdo_o);

  // Start request coincides with the busy flag.
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> (!sdo_o && state == ST_CONVERT));

  // Converter completion raises the line and waits for the host.
  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONVERT && conv_done_i) |=> (state == ST_READY && sdo_o));

  // Expired watchdog lands in idle with the line high.
  assert_tmo_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (state == ST_IDLE && sdo_o));

  // Watchdog cannot fire outside the shift state.
  assert_tmo_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |-> state == ST_SHIFT);

  // Falling edge after the last bit returns to idle for a restart.
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && line_fall && frame_done) |=> state == ST_IDLE);

  // Start request lasts exactly one cycle.
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

endmodule

// File: tb/serial_readout_slave_tb.sv
module serial_readout_slave_tb;

  localparam int NCH      = 11;
  localparam int CB       = 8;
  localparam int FB       = NCH * CB;
  localparam int BUSY     = 10;   // 500 ns at 20 MHz
  localparam int TMO      = 400;  // 20 us at 20 MHz
  localparam int CONV_LAT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host = 1'b1;
  logic          done_auto = 1'b0;
  logic          done_man = 1'b0;
  logic [FB-1:0] bus = '0;
  logic          sdo;
  logic          conv_start;
  logic          conv_done;

  assign conv_done = done_auto | done_man;

  always #2 clk = ~clk;

  serial_readout_slave #(
    .CLK_HZ     (20_000_000),
    .BUSY_NS    (500),
    .TIMEOUT_NS (20_000),
    .NUM_CH     (NCH),
    .CH_BITS    (CB)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_line_i  (host),
    .sdo_o        (sdo),
    .conv_start_o (conv_start),
    .conv_done_i  (conv_done),
    .conv_data_i  (bus)
  );

  int checks = 0;
  int fails = 0;
  int start_pulses = 0;
  int start_width = 0;
  int max_start_width = 0;
  int lat = 0;
  bit finished = 0;

  // Converter model: done pulse CONV_LAT cycles after a start request.
  always @(posedge clk) begin
    done_auto <= 1'b0;
    if (conv_start) lat <= CONV_LAT;
    else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) done_auto <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (conv_start) begin
      start_width++;
      if (start_width == 1) start_pulses++;
      if (start_width > max_start_width) max_start_width = start_width;
    end else start_width = 0;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] make_frame(input logic [7:0] salt);
    logic [FB-1:0] f;
    for (int k = 0; k < NCH; k++) f[k*CB +: CB] = 8'h5A ^ 8'(k * 19) ^ salt;
    return f;
  endfunction

  task automatic drive(input logic v);
    @(posedge clk);
    #1 host = v;
  endtask

  // Host pulls low from idle; check busy delay, start pulse, ready.
  task automatic begin_cycle();
    int n = 0;
    int m = 0;
    int p0 = start_pulses;
    drive(1'b0);
    @(negedge clk);
    while (sdo !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    chk("R2", "busy delay in window", (n >= BUSY && n <= BUSY + 6), 1);
    while (sdo !== 1'b1 && m < 100) begin @(negedge clk); m++; end
    chk("R3", "ready after done", (m <= CONV_LAT + 4), 1);
    chk("R2", "one start pulse per cycle", start_pulses, p0 + 1);
    chk("R9", "start pulse width", max_start_width, 1);
  endtask

  // Clock out bits [first, first+count); optional long low after bit long_idx.
  task automatic read_bits(input logic [FB-1:0] exp, input int first, input int count,
                           input int h, input int l, input int long_idx);
    for (int i = first; i < first + count; i++) begin
      drive(1'b1);
      repeat (h - 1) @(posedge clk);
      #1 host = 1'b0;
      @(negedge clk);
      chk((i == long_idx + 1) ? "R7" : "R4", $sformatf("frame bit %0d", i), sdo, exp[i]);
      if (i != FB - 1) repeat ((i == long_idx) ? 1000 : l) @(posedge clk);
    end
  endtask

  // Host left low after the last bit: block must convert again.
  task automatic await_restart();
    int n = 0;
    int p0 = start_pulses;
    while (start_pulses == p0 && n < 200) begin @(negedge clk); n++; end
    chk("R8", "new conversion after last bit", start_pulses, p0 + 1);
    n = 0;
    while (sdo !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk("R3", "ready after restart", sdo, 1);
  endtask

  // Raise the host line and let the watchdog return the block to idle.
  task automatic abandon();
    drive(1'b1);
    repeat (TMO + 50) @(posedge clk);
    @(negedge clk);
    chk("R6", "idle after abandon", sdo, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", "sdo in reset", sdo, 1);
    chk("R1", "start in reset", conv_start, 0);
    #1 rst_n = 1'b1;
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R1", "sdo idle high", sdo, 1);
    chk("R1", "no start while idle", start_pulses, 0);
  endtask

  task automatic t_basic();
    logic [FB-1:0] f0 = make_frame(8'h00);
    logic [FB-1:0] f1 = make_frame(8'hC3);
    bus = f0;
    begin_cycle();
    read_bits(f0, 0, FB, 4, 3, -1);
    bus = f1;
    await_restart();
    read_bits(f1, 0, FB, 7, 1, -1);
    abandon();
  endtask

  task automatic t_ignore_done();
    logic [FB-1:0] f2 = make_frame(8'h3C);
    logic [FB-1:0] f3 = make_frame(8'hFF);
    bus = f2;
    begin_cycle();
    bus = f3;
    @(posedge clk); #1 done_man = 1'b1;
    @(posedge clk); #1 done_man = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R5", "still ready after stray done", sdo, 1);
    read_bits(f2, 0, 24, 5, 2, -1);
    @(posedge clk); #1 done_man = 1'b1;
    @(posedge clk); #1 done_man = 1'b0;
    read_bits(f2, 24, FB - 24, 5, 2, -1);
    abandon();
  endtask

  task automatic t_long_low();
    logic [FB-1:0] f4 = make_frame(8'h96);
    bus = f4;
    begin_cycle();
    repeat (1000) @(posedge clk);
    @(negedge clk);
    chk("R7", "no timeout before first rise", sdo, 1);
    read_bits(f4, 0, FB, 4, 2, 40);
    abandon();
  endtask

  task automatic t_timeout();
    logic [FB-1:0] f0 = make_frame(8'h00);
    int p0;
    bus = f0;
    begin_cycle();
    read_bits(f0, 0, 5, 4, 3, -1);
    drive(1'b1);
    repeat (TMO - 20) @(posedge clk);
    @(negedge clk);
    chk("R6", "bit 5 held before expiry", sdo, f0[5]);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R6", "idle after expiry", sdo, 1);
    p0 = start_pulses;
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk("R1", "idle holds with host high", sdo, 1);
    chk("R1", "no start while host high", start_pulses, p0);
    begin_cycle();
    read_bits(f0, 0, FB, 4, 3, -1);
    abandon();
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_ignore_done();
    t_long_low();
    t_timeout();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule